// File: doc/BRIEF.md
# PCI Configuration Address Translator

This block sits between a 32-bit processor-side register window and a PCI host's configuration port. Each access to the south-bridge configuration window carries three things: a 16-bit offset inside the window, a size (byte, half-word or word) and, for writes, the data. The block joins the offset with a 16-bit upper-address value taken from a mapping register. It decodes the one-hot device-select field of the joined value and produces a standard type-0 configuration address with the enable bit set.

An access is suppressed when the mapping register selects a non-type-0 cycle, when it is misaligned for its size, or when the device-select field is empty. A suppressed read returns all ones at its width. A translated read returns the downstream data, trimmed to the access width.

The block also keeps a local 16-bit status word. It records received master aborts and received target aborts. Every translated access clears both flags, so the next access starts with a clean status.

Top module: `pcicfg_xlate`

## Requirements
- R1: After reset, cfg_valid_o, rsp_valid_o and err_o are low and stat_o is 0x0000.
- R2: The joined 32-bit address has map_upper_i in bits 31:16 and req_off_i in bits 15:0.
- R3: The device number is the index, counted from bit 11 of the joined address, of the lowest set bit in joined bits 31:11. Every higher set bit is ignored.
- R4: The function number is joined bits 10:8 and the register number is joined bits 7:2.
- R5: On a translated access, cfg_addr_o is built as follows:
  - bit 31 is 1 and bits 30:24 are 0;
  - bits 23:16 are bus_num_i, bits 15:11 the device, bits 10:8 the function and bits 7:2 the register;
  - bits 1:0 are 0.

  cfg_lane_o carries req_off_i[1:0] and cfg_size_o carries the size code. cfg_wdata_o is req_wdata_i with the bits above the access width forced to zero.
- R6: A request in the cycle where req_i is high is presented in the next cycle. That cycle carries cfg_valid_o (if translated) and, for reads only, rsp_valid_o. A new request is accepted every cycle.
- R7: When map_type1_i is 1, the access is suppressed without error. A read returns 0xFF, 0xFFFF or 0xFFFFFFFF for size codes 0, 1 and 2, and a write causes no cfg_valid_o.
- R8: Size code 0 is byte, 1 is half-word, 2 is word and 3 is invalid. The following cases raise err_o, suppress the access and make a read return all ones at the access width (32 bits for code 3):
  - a half-word with req_off_i[0]=1;
  - a word with req_off_i[1:0]≠0;
  - size code 3.
- R9: When joined bits 31:11 are all zero on a type-0 access, err_o is raised, the access is suppressed and a read returns all ones at the access width.
- R10: A translated read returns cfg_rdata_i with the bits above the access width forced to zero.
- R11: A pulse on abort_master_i sets stat_o bit 13, and a pulse on abort_target_i sets stat_o bit 12. Both bits are cleared at the end of each cycle with cfg_valid_o high. A set arriving in that same cycle wins over the clear.
- R12: A suppressed access leaves stat_o unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Access request, one per cycle |
| req_write_i | input | 1 | 1 = write, 0 = read |
| req_size_i | input | 2 | Access size code (0 byte, 1 half, 2 word) |
| req_off_i | input | 16 | Offset inside the configuration window |
| req_wdata_i | input | 32 | Write data, right-justified |
| map_upper_i | input | 16 | Upper address half from the mapping register |
| map_type1_i | input | 1 | Type-select bit; 1 suppresses translation |
| bus_num_i | input | 8 | Static bus number |
| abort_master_i | input | 1 | Received-master-abort event |
| abort_target_i | input | 1 | Received-target-abort event |
| cfg_valid_o | output | 1 | Translated configuration cycle strobe |
| cfg_write_o | output | 1 | Configuration cycle is a write |
| cfg_size_o | output | 2 | Size code of the configuration cycle |
| cfg_lane_o | output | 2 | Byte offset within the dword |
| cfg_addr_o | output | 32 | Type-0 configuration address |
| cfg_wdata_o | output | 32 | Width-trimmed write data |
| cfg_rdata_i | input | 32 | Downstream read data, right-justified |
| rsp_valid_o | output | 1 | Read response strobe |
| rsp_rdata_o | output | 32 | Read response data |
| err_o | output | 1 | Misaligned or empty device-select access |
| stat_o | output | 16 | Local status word |

## Verification
The hardest situation to reach is an abort event landing in the same cycle as a translated access, since the clear and the set then race on the same flags. The bench starts a translated read and raises abort_master_i at the negative edge between the request edge and the clear edge. It then checks that the flag survives. The lowest-set-bit rule is driven with device-select fields that hold several set bits at once, and also with fields whose only set bit is bit 11 or bit 31.

// File: rtl/pcicfg_pkg.sv
package pcicfg_pkg;

  localparam int unsigned DATA_W   = 32;
  localparam int unsigned STAT_W   = 16;
  localparam int unsigned SEL_LSB  = 11;
  localparam int unsigned DEV_FW   = 5;
  localparam int unsigned RMA_BIT  = 13;
  localparam int unsigned RTA_BIT  = 12;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_HALF = 2'd1,
    SZ_WORD = 2'd2,
    SZ_BAD  = 2'd3
  } acc_size_e;

  typedef struct packed {
    logic              write;
    acc_size_e         size;
    logic [1:0]        lane;
    logic [DATA_W-1:0] addr;
    logic [DATA_W-1:0] wdata;
    logic              issue;
    logic              err;
  } xl_req_t;

  function automatic logic [DATA_W-1:0] width_mask(acc_size_e s);
    case (s)
      SZ_BYTE: width_mask = DATA_W'(32'h0000_00FF);
      SZ_HALF: width_mask = DATA_W'(32'h0000_FFFF);
      default: width_mask = '1;
    endcase
  endfunction

endpackage

// File: rtl/pcicfg_lsb_find.sv
module pcicfg_lsb_find #(
  parameter int unsigned W = 21,
  localparam int unsigned IDX_W = (W > 1) ? $clog2(W) : 1
) (
  input  logic [W-1:0]     vec_i,
  output logic [IDX_W-1:0] idx_o,
  output logic             hit_o
);

  // prefix OR from the bottom: seen[i] = any bit below i set
  logic [W:0] seen;
  logic [W-1:0] first;

  assign seen[0] = 1'b0;
  for (genvar i = 0; i < W; i++) begin : g_pre
    assign seen[i+1] = seen[i] | vec_i[i];
    assign first[i]  = vec_i[i] & ~seen[i];
  end

  always_comb begin
    idx_o = '0;
    for (int i = 0; i < W; i++) begin
      if (first[i]) idx_o = idx_o | IDX_W'(i);
    end
  end

  assign hit_o = seen[W];

endmodule

// File: rtl/pcicfg_decode.sv
module pcicfg_decode
  import pcicfg_pkg::*;
#(
  parameter int unsigned OFF_W = 16,
  parameter int unsigned MAP_W = 16,
  localparam int unsigned COMB_W  = OFF_W + MAP_W,
  localparam int unsigned SEL_W   = COMB_W - SEL_LSB,
  localparam int unsigned SEL_IDX = (SEL_W > 1) ? $clog2(SEL_W) : 1
) (
  input  logic              write_i,
  input  logic [1:0]        size_i,
  input  logic [OFF_W-1:0]  off_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [MAP_W-1:0]  upper_i,
  input  logic              type1_i,
  input  logic [7:0]        bus_i,
  output xl_req_t           req_o
);

  logic [COMB_W-1:0]  joined;
  logic [SEL_W-1:0]   sel;
  logic [SEL_IDX-1:0] dev_idx;
  logic               sel_hit;
  logic               misalign;
  acc_size_e          sz;

  assign joined = {upper_i, off_i};
  assign sel    = joined[COMB_W-1:SEL_LSB];
  assign sz     = acc_size_e'(size_i);

  pcicfg_lsb_find #(.W(SEL_W)) u_lsb (
    .vec_i (sel),
    .idx_o (dev_idx),
    .hit_o (sel_hit)
  );

  always_comb begin
    case (sz)
      SZ_BYTE: misalign = 1'b0;
      SZ_HALF: misalign = off_i[0];
      SZ_WORD: misalign = |off_i[1:0];
      default: misalign = 1'b1;
    endcase
  end

  always_comb begin
    req_o.write = write_i;
    req_o.size  = sz;
    req_o.lane  = off_i[1:0];
    req_o.addr  = {1'b1, 7'd0, bus_i, DEV_FW'(dev_idx),
                   joined[10:8], joined[7:2], 2'b00};
    req_o.wdata = wdata_i & width_mask(sz);
    req_o.issue = !type1_i && !misalign && sel_hit;
    req_o.err   = !type1_i && (misalign || !sel_hit);
  end

endmodule

// File: rtl/pcicfg_status.sv
module pcicfg_status
  import pcicfg_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              set_rma_i,
  input  logic              set_rta_i,
  input  logic              clr_i,
  output logic [STAT_W-1:0] stat_o
);

  logic rma_q, rta_q;

  // set after clear: an abort in the clearing cycle survives
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rma_q <= 1'b0;
      rta_q <= 1'b0;
    end else begin
      if (clr_i) begin
        rma_q <= 1'b0;
        rta_q <= 1'b0;
      end
      if (set_rma_i) rma_q <= 1'b1;
      if (set_rta_i) rta_q <= 1'b1;
    end
  end

  always_comb begin
    stat_o          = '0;
    stat_o[RMA_BIT] = rma_q;
    stat_o[RTA_BIT] = rta_q;
  end

endmodule

// File: rtl/pcicfg_rsp.sv
module pcicfg_rsp
  import pcicfg_pkg::*;
(
  input  logic              issue_i,
  input  acc_size_e         size_i,
  input  logic [DATA_W-1:0] rdata_i,
  output logic [DATA_W-1:0] rdata_o
);

  logic [DATA_W-1:0] m;

  assign m       = width_mask(size_i);
  assign rdata_o = issue_i ? (rdata_i & m) : m;

endmodule

// File: rtl/pcicfg_xlate.sv
module pcicfg_xlate
  import pcicfg_pkg::*;
#(
  parameter int unsigned OFF_W = 16,
  parameter int unsigned MAP_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              req_write_i,
  input  logic [1:0]        req_size_i,
  input  logic [OFF_W-1:0]  req_off_i,
  input  logic [31:0]       req_wdata_i,
  input  logic [MAP_W-1:0]  map_upper_i,
  input  logic              map_type1_i,
  input  logic [7:0]        bus_num_i,
  input  logic              abort_master_i,
  input  logic              abort_target_i,
  output logic              cfg_valid_o,
  output logic              cfg_write_o,
  output logic [1:0]        cfg_size_o,
  output logic [1:0]        cfg_lane_o,
  output logic [31:0]       cfg_addr_o,
  output logic [31:0]       cfg_wdata_o,
  input  logic [31:0]       cfg_rdata_i,
  output logic              rsp_valid_o,
  output logic [31:0]       rsp_rdata_o,
  output logic              err_o,
  output logic [15:0]       stat_o
);

  xl_req_t dec, stg_q;
  logic    stg_v_q;

  pcicfg_decode #(.OFF_W(OFF_W), .MAP_W(MAP_W)) u_dec (
    .write_i (req_write_i),
    .size_i  (req_size_i),
    .off_i   (req_off_i),
    .wdata_i (req_wdata_i),
    .upper_i (map_upper_i),
    .type1_i (map_type1_i),
    .bus_i   (bus_num_i),
    .req_o   (dec)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stg_v_q <= 1'b0;
      stg_q   <= '0;
    end else begin
      stg_v_q <= req_i;
      if (req_i) stg_q <= dec;
    end
  end

  assign cfg_valid_o = stg_v_q && stg_q.issue;
  assign cfg_write_o = stg_q.write;
  assign cfg_size_o  = stg_q.size;
  assign cfg_lane_o  = stg_q.lane;
  assign cfg_addr_o  = stg_q.addr;
  assign cfg_wdata_o = stg_q.wdata;
  assign rsp_valid_o = stg_v_q && !stg_q.write;
  assign err_o       = stg_v_q && stg_q.err;

  pcicfg_rsp u_rsp (
    .issue_i (stg_q.issue),
    .size_i  (stg_q.size),
    .rdata_i (cfg_rdata_i),
    .rdata_o (rsp_rdata_o)
  );

  pcicfg_status u_stat (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .set_rma_i (abort_master_i),
    .set_rta_i (abort_target_i),
    .clr_i     (cfg_valid_o),
    .stat_o    (stat_o)
  );

endmodule

// File: rtl/pcicfg_xlate_chk.sv
module pcicfg_xlate_chk #(
  parameter int unsigned OFF_W = 16,
  parameter int unsigned MAP_W = 16
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             req_i,
  input logic             req_write_i,
  input logic [1:0]       req_size_i,
  input logic [OFF_W-1:0] req_off_i,
  input logic [MAP_W-1:0] map_upper_i,
  input logic             map_type1_i,
  input logic             abort_master_i,
  input logic             abort_target_i,
  input logic             cfg_valid_o,
  input logic [1:0]       cfg_size_o,
  input logic [31:0]      cfg_addr_o,
  input logic             rsp_valid_o,
  input logic [31:0]      rsp_rdata_o,
  input logic             err_o,
  input logic [15:0]      stat_o
);

  assert_cfg_format_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_valid_o |-> cfg_addr_o[31] && cfg_addr_o[30:24] == 7'd0 && cfg_addr_o[1:0] == 2'd0);

  assert_dev_range_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_valid_o |-> cfg_addr_o[15:11] < 5'(OFF_W + MAP_W - 11));

  assert_read_latency_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_i && !req_write_i |=> rsp_valid_o);

  assert_write_silent_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_i && req_write_i |=> !rsp_valid_o);

  assert_type1_drop_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_i && map_type1_i |=> !cfg_valid_o && !err_o);

  assert_word_align_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_i && !map_type1_i && req_size_i == 2'd2 && req_off_i[1:0] != 2'd0
    |=> err_o && !cfg_valid_o);

  assert_empty_sel_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_i && !map_type1_i && map_upper_i == '0 && req_off_i[OFF_W-1:11] == '0
    |=> err_o && !cfg_valid_o);

  assert_suppress_ones_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o && !cfg_valid_o |-> rsp_rdata_o[7:0] == 8'hFF);

  assert_byte_trim_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o && cfg_valid_o && cfg_size_o == 2'd0 |-> rsp_rdata_o[31:8] == 24'd0);

  assert_stat_clear_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_valid_o && !abort_master_i && !abort_target_i |=> stat_o[13:12] == 2'b00);

  assert_stat_hold_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cfg_valid_o && !abort_master_i && !abort_target_i |=> $stable(stat_o));

endmodule

bind pcicfg_xlate pcicfg_xlate_chk #(.OFF_W(OFF_W), .MAP_W(MAP_W)) u_chk (
  .clk_i          (clk_i),
  .rst_ni         (rst_ni),
  .req_i          (req_i),
  .req_write_i    (req_write_i),
  .req_size_i     (req_size_i),
  .req_off_i      (req_off_i),
  .map_upper_i    (map_upper_i),
  .map_type1_i    (map_type1_i),
  .abort_master_i (abort_master_i),
  .abort_target_i (abort_target_i),
  .cfg_valid_o    (cfg_valid_o),
  .cfg_size_o     (cfg_size_o),
  .cfg_addr_o     (cfg_addr_o),
  .rsp_valid_o    (rsp_valid_o),
  .rsp_rdata_o    (rsp_rdata_o),
  .err_o          (err_o),
  .stat_o         (stat_o)
);

// File: tb/sim_pcicfg_xlate.sv
module sim_pcicfg_xlate;

  localparam int CLK_PERIOD = 10;
  localparam logic [7:0] BUS = 8'h03;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        req_i = 1'b0, req_write_i = 1'b0;
  logic [1:0]  req_size_i = 2'd0;
  logic [15:0] req_off_i = '0;
  logic [31:0] req_wdata_i = '0;
  logic [15:0] map_upper_i = '0;
  logic        map_type1_i = 1'b0;
  logic        abort_master_i = 1'b0, abort_target_i = 1'b0;
  logic        cfg_valid_o, cfg_write_o;
  logic [1:0]  cfg_size_o, cfg_lane_o;
  logic [31:0] cfg_addr_o, cfg_wdata_o, cfg_rdata_i, rsp_rdata_o;
  logic        rsp_valid_o, err_o;
  logic [15:0] stat_o;

  int errors = 0;
  int checks = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pcicfg_xlate u0 (
    .clk_i(clk), .rst_ni(rst_ni), .req_i(req_i), .req_write_i(req_write_i),
    .req_size_i(req_size_i), .req_off_i(req_off_i), .req_wdata_i(req_wdata_i),
    .map_upper_i(map_upper_i), .map_type1_i(map_type1_i), .bus_num_i(BUS),
    .abort_master_i(abort_master_i), .abort_target_i(abort_target_i),
    .cfg_valid_o(cfg_valid_o), .cfg_write_o(cfg_write_o), .cfg_size_o(cfg_size_o),
    .cfg_lane_o(cfg_lane_o), .cfg_addr_o(cfg_addr_o), .cfg_wdata_o(cfg_wdata_o),
    .cfg_rdata_i(cfg_rdata_i), .rsp_valid_o(rsp_valid_o), .rsp_rdata_o(rsp_rdata_o),
    .err_o(err_o), .stat_o(stat_o)
  );

  function automatic logic [31:0] stub_data(input logic [31:0] a, input logic [1:0] ln);
    return {a[15:0], 8'hA5, 6'd0, ln} ^ 32'h0F0F_0000;
  endfunction

  // downstream config stub
  always_comb cfg_rdata_i = cfg_valid_o ? stub_data(cfg_addr_o, cfg_lane_o) : 32'hDEAD_BEEF;

  function automatic logic [31:0] exp_addr(input logic [15:0] up, input logic [15:0] off);
    logic [31:0] c;
    int dev;
    c = {up, off};
    dev = -1;
    for (int i = 11; i < 32; i++) if (c[i] && dev < 0) dev = i - 11;
    return {1'b1, 7'd0, BUS, dev[4:0], c[10:8], c[7:2], 2'b00};
  endfunction

  function automatic logic [31:0] msk(input logic [1:0] s);
    return (s == 2'd0) ? 32'hFF : (s == 2'd1) ? 32'hFFFF : 32'hFFFF_FFFF;
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // drive one request, return in the cycle after it was taken
  task automatic access(input logic w, input logic [1:0] sz, input logic [15:0] up,
                        input logic [15:0] off, input logic [31:0] wd, input logic t1);
    @(negedge clk);
    req_i = 1'b1; req_write_i = w; req_size_i = sz; req_off_i = off;
    req_wdata_i = wd; map_upper_i = up; map_type1_i = t1;
    @(negedge clk);
    req_i = 1'b0;
  endtask

  task automatic t_read(input string tag, input logic [1:0] sz, input logic [15:0] up,
                        input logic [15:0] off);
    logic [31:0] ea;
    ea = exp_addr(up, off);
    access(1'b0, sz, up, off, 32'h0, 1'b0);
    chk({tag, " cfg_valid"}, {31'd0, cfg_valid_o}, 32'd1);
    chk({tag, " addr"}, cfg_addr_o, ea);
    chk({tag, " lane"}, {30'd0, cfg_lane_o}, {30'd0, off[1:0]});
    chk({tag, " rdata"}, rsp_rdata_o, stub_data(ea, off[1:0]) & msk(sz));
    chk({tag, " rsp_valid/err"}, {30'd0, rsp_valid_o, err_o}, 32'd2);
  endtask

  task automatic t_suppressed(input string tag, input logic [1:0] sz, input logic [15:0] up,
                              input logic [15:0] off, input logic t1, input logic exp_err);
    access(1'b0, sz, up, off, 32'h0, t1);
    chk({tag, " no cfg"}, {31'd0, cfg_valid_o}, 32'd0);
    chk({tag, " ones"}, rsp_rdata_o, msk(sz));
    chk({tag, " err"}, {31'd0, err_o}, {31'd0, exp_err});
  endtask

  task automatic t_reset();
    chk("R1 cfg_valid", {31'd0, cfg_valid_o}, 32'd0);
    chk("R1 rsp_valid", {31'd0, rsp_valid_o}, 32'd0);
    chk("R1 err", {31'd0, err_o}, 32'd0);
    chk("R1 stat", {16'd0, stat_o}, 32'd0);
  endtask

  task automatic t_writes();
    access(1'b1, 2'd0, 16'h0004, 16'h0213, 32'hAABB_CCDD, 1'b0);
    chk("R5 byte write valid", {30'd0, cfg_valid_o, cfg_write_o}, 32'd3);
    chk("R5 byte wdata trim", cfg_wdata_o, 32'h0000_00DD);
    chk("R5 byte write addr", cfg_addr_o, exp_addr(16'h0004, 16'h0213));
    chk("R6 write no rsp", {31'd0, rsp_valid_o}, 32'd0);
    access(1'b1, 2'd2, 16'h0001, 16'h0008, 32'h1234_5678, 1'b0);
    chk("R5 word wdata", cfg_wdata_o, 32'h1234_5678);
    chk("R5 size", {30'd0, cfg_size_o}, 32'd2);
    access(1'b1, 2'd1, 16'h0002, 16'h0106, 32'hFFFF_9876, 1'b1);
    chk("R7 type1 write dropped", {30'd0, cfg_valid_o, err_o}, 32'd0);
  endtask

  task automatic t_back_to_back();
    @(negedge clk);
    req_i = 1'b1; req_write_i = 1'b0; req_size_i = 2'd2; map_type1_i = 1'b0;
    map_upper_i = 16'h0010; req_off_i = 16'h0004;
    @(negedge clk);
    chk("R6 first of pair", cfg_addr_o, exp_addr(16'h0010, 16'h0004));
    map_upper_i = 16'h0000; req_off_i = 16'h1A0C;
    @(negedge clk);
    req_i = 1'b0;
    chk("R6 second of pair", cfg_addr_o, exp_addr(16'h0000, 16'h1A0C));
    chk("R6 second valid", {31'd0, cfg_valid_o}, 32'd1);
  endtask

  task automatic t_status();
    @(negedge clk);
    abort_master_i = 1'b1; abort_target_i = 1'b1;
    @(negedge clk);
    abort_master_i = 1'b0; abort_target_i = 1'b0;
    chk("R11 flags set", {16'd0, stat_o}, 32'h3000);
    t_suppressed("R12 type1 keeps stat", 2'd0, 16'h0002, 16'h0100, 1'b1, 1'b0);
    @(negedge clk);
    chk("R12 stat held", {16'd0, stat_o}, 32'h3000);
    t_suppressed("R12 err keeps stat", 2'd2, 16'h0000, 16'h0004, 1'b0, 1'b1);
    @(negedge clk);
    chk("R12 stat held after err", {16'd0, stat_o}, 32'h3000);
    access(1'b0, 2'd2, 16'h0002, 16'h0000, 32'h0, 1'b0);
    @(negedge clk);
    chk("R11 cleared by access", {16'd0, stat_o}, 32'h0000);
    // abort arriving in the clearing cycle
    access(1'b0, 2'd2, 16'h0002, 16'h0000, 32'h0, 1'b0);
    abort_master_i = 1'b1;
    @(negedge clk);
    abort_master_i = 1'b0;
    chk("R11 set wins over clear", {16'd0, stat_o}, 32'h2000);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_ni = 1'b1;
    @(negedge clk);
    t_reset();
    t_read("R2 R4 byte read", 2'd0, 16'h0002, 16'h0312);
    t_read("R3 top sel bit", 2'd1, 16'h8000, 16'h0536);
    t_read("R3 lowest of many", 2'd2, 16'h00C0, 16'h0800);
    t_read("R3 lowest multi upper", 2'd2, 16'h0A40, 16'hF0FC);
    t_read("R10 half trim", 2'd1, 16'h0020, 16'h07FE);
    t_writes();
    t_suppressed("R7 type1 byte", 2'd0, 16'h0002, 16'h0101, 1'b1, 1'b0);
    t_suppressed("R7 type1 half", 2'd1, 16'h0002, 16'h0102, 1'b1, 1'b0);
    t_suppressed("R7 type1 word", 2'd2, 16'h0002, 16'h0104, 1'b1, 1'b0);
    t_suppressed("R8 half misalign", 2'd1, 16'h0000, 16'h0801, 1'b0, 1'b1);
    t_suppressed("R8 word misalign", 2'd2, 16'h0000, 16'h0802, 1'b0, 1'b1);
    t_suppressed("R8 bad size", 2'd3, 16'h0001, 16'h0000, 1'b0, 1'b1);
    t_suppressed("R9 empty select", 2'd2, 16'h0000, 16'h0704, 1'b0, 1'b1);
    t_back_to_back();
    t_status();
    repeat (2) @(negedge clk);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule